// File: doc/BRIEF.md
# Stereo Silence Detector

This block watches a decoded stereo sample stream, one left and one right word per frame, with a single-cycle strobe marking each frame. It keeps a count of how many frames in a row have carried a value of exactly zero on both channels. Once that count reaches a fixed run length, it raises one shared flag. A high flag means no input is present. A low flag means audio data is arriving.

The flag is meant to drive power management outside the block. For example, the flag can be inverted and fed to an amplifier's shutdown control so the output stage powers down during long silence. Time is measured in frames (word-clock periods), not in system-clock cycles, so the block works the same at any ratio of system clock to sample rate.

The run length defaults to 1024 frames and the sample width to 24 bits. Both are parameters.

Top module: `zero_input_detect`

## Requirements
- R1: While `rst_n` is low, `silence_flag` is 0 and the frame count is cleared. After reset is released, a full run of `RUN_LEN` silent frames is needed before the flag rises, even if silent frames were counted before the reset.
- R2: A strobed frame in which both `left_sample` and `right_sample` equal zero is a silent frame. The flag is 0 in the cycle after the (`RUN_LEN`-1)th consecutive silent frame. It is 1 in the cycle after the `RUN_LEN`th such frame.
- R3: A strobed frame with a nonzero value on either channel clears the count to zero and drives the flag to 0 in the next cycle. This applies whether the nonzero value is on the left channel alone or on the right channel alone.
- R4: Only cycles with `frame_valid` high advance the count. In cycles with `frame_valid` low, the count and the flag hold, whatever the sample inputs carry. This holds both while the flag is high and while a run is being counted.
- R5: The count saturates at `RUN_LEN`. The flag stays at 1 for any number of further silent frames, with no wraparound.
- R6: There is one flag for both channels. A run in which one channel is always zero and the other is nonzero never raises it.
- R7: Every bit of a sample is tested, with the sample read as two's complement. Both the value 1 (lowest bit only) and the most negative value (top bit only) count as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_valid | input | 1 | One-cycle strobe marking a new left/right sample pair |
| left_sample | input | SAMPLE_W | Left channel sample, two's complement |
| right_sample | input | SAMPLE_W | Right channel sample, two's complement |
| silence_flag | output | 1 | 1 when both channels have been zero for RUN_LEN frames |

## Verification
The bench checks the exact edge of the threshold: a design that is off by one raises the flag one frame early or one frame late. It interleaves idle cycles that carry nonzero data between the strobes. A design that counts clock cycles, or that samples data without the strobe, would rise early or clear by mistake. It checks each channel alone and the extreme one-bit values, to catch a design that tests only one channel or only some bits. It runs long silence to expose a counter that wraps, and it resets in the middle of a run to catch a design that keeps stale progress.

// File: rtl/zd_pkg.sv
package zd_pkg;

    // Classification of the current cycle as seen by the run counter.
    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,   // no strobe this cycle
        FR_SILENT = 2'd1,   // strobed frame, every channel zero
        FR_ACTIVE = 2'd2    // strobed frame, some channel nonzero
    } frame_kind_e;

endpackage

// File: rtl/zd_chan_zero.sv
module zd_chan_zero #(
    parameter int SAMPLE_W = 24,
    parameter int NUM_CH   = 2
) (
    input  logic [NUM_CH-1:0][SAMPLE_W-1:0] samples,
    output logic                            all_zero
);

    logic [NUM_CH-1:0] ch_zero;

    // One full-width zero compare per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_zero[c] = (samples[c] == '0);
    end

    assign all_zero = &ch_zero;

endmodule

// File: rtl/zd_frame_class.sv
module zd_frame_class
    import zd_pkg::*;
(
    input  logic        strobe,
    input  logic        all_zero,
    output frame_kind_e kind
);

    always_comb begin
        if (!strobe) begin
            kind = FR_IDLE;
        end else if (all_zero) begin
            kind = FR_SILENT;
        end else begin
            kind = FR_ACTIVE;
        end
    end

endmodule

// File: rtl/zd_run_counter.sv
module zd_run_counter
    import zd_pkg::*;
#(
    parameter int RUN_LEN = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  frame_kind_e kind,
    output logic        flag
);

    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(RUN_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             flag;
    } run_state_t;

    run_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (kind)
            FR_SILENT: begin
                if (st_q.count != LIMIT) begin
                    st_d.count = st_q.count + 1'b1;
                end
                st_d.flag = (st_q.count >= LIMIT_M1);
            end
            FR_ACTIVE: begin
                st_d.count = '0;
                st_d.flag  = 1'b0;
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/zero_input_detect.sv
module zero_input_detect
    import zd_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int RUN_LEN  = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_valid,
    input  logic [SAMPLE_W-1:0] left_sample,
    input  logic [SAMPLE_W-1:0] right_sample,
    output logic                silence_flag
);

    localparam int NUM_CH = 2;

    logic [NUM_CH-1:0][SAMPLE_W-1:0] ch_samples;
    logic                            both_zero;
    frame_kind_e                     kind;

    assign ch_samples[0] = left_sample;
    assign ch_samples[1] = right_sample;

    zd_chan_zero #(
        .SAMPLE_W (SAMPLE_W),
        .NUM_CH   (NUM_CH)
    ) u_zero (
        .samples  (ch_samples),
        .all_zero (both_zero)
    );

    zd_frame_class u_class (
        .strobe   (frame_valid),
        .all_zero (both_zero),
        .kind     (kind)
    );

    zd_run_counter #(
        .RUN_LEN (RUN_LEN)
    ) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .flag  (silence_flag)
    );

endmodule

// File: rtl/zd_checker.sv
module zd_checker #(
    parameter int SAMPLE_W = 24,
    parameter int RUN_LEN  = 1024
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_valid,
    input logic [SAMPLE_W-1:0] left_sample,
    input logic [SAMPLE_W-1:0] right_sample,
    input logic                silence_flag
);

    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

    logic silent_frame;
    logic active_frame;
    logic [CNT_W-1:0] zrun_q;

    assign silent_frame = frame_valid && (left_sample == '0) && (right_sample == '0);
    assign active_frame = frame_valid && !((left_sample == '0) && (right_sample == '0));

    // Independent tally of consecutive silent frames, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zrun_q <= '0;
        end else if (active_frame) begin
            zrun_q <= '0;
        end else if (silent_frame && zrun_q != LIMIT) begin
            zrun_q <= zrun_q + 1'b1;
        end
    end

    // R2, R5: flag high exactly when the silent run has reached the limit
    a_r2_flag_tracks_run: assert property (@(posedge clk) disable iff (!rst_n)
        silence_flag == (zrun_q == LIMIT));

    // R3: nonzero frame on either channel clears the flag next cycle
    a_r3_data_clears: assert property (@(posedge clk) disable iff (!rst_n)
        active_frame |=> !silence_flag);

    // R4: without a strobe the flag holds
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> $stable(silence_flag));

    // R5: once high, further silent frames keep it high
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (silence_flag && silent_frame) |=> silence_flag);

    // R6: a rise is only ever caused by a strobed all-zero frame
    a_r6_rise_on_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(silence_flag) |-> $past(silent_frame));

endmodule

bind zero_input_detect zd_checker #(
    .SAMPLE_W (SAMPLE_W),
    .RUN_LEN  (RUN_LEN)
) u_zd_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_valid  (frame_valid),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .silence_flag (silence_flag)
);

// File: tb/sim_zero_input_detect.sv
module sim_zero_input_detect;

    localparam int W       = 24;
    localparam int RUN_LEN = 1024;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_valid = 1'b0;
    logic [W-1:0] left_sample = '0;
    logic [W-1:0] right_sample = '0;
    logic         silence_flag;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    int    run = 0;
    bit    exp_flag = 0;
    string exp_tag = "R1 reset";

    always #10 clk = ~clk;

    zero_input_detect #(.SAMPLE_W(W), .RUN_LEN(RUN_LEN)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_valid  (frame_valid),
        .left_sample  (left_sample),
        .right_sample (right_sample),
        .silence_flag (silence_flag)
    );

    // Compare the output with the prediction made in the previous step.
    task automatic check_now();
        checks++;
        if (silence_flag !== exp_flag) begin
            failures++;
            $display("FAIL %s: silence_flag=%0b expected %0b (t=%0t)",
                     exp_tag, silence_flag, exp_flag, $time);
        end
    endtask

    // One cycle: check at the falling edge, drive, then predict the next edge.
    task automatic step(input logic v, input logic [W-1:0] l, input logic [W-1:0] r,
                        input string tag);
        @(negedge clk);
        check_now();
        frame_valid  = v;
        left_sample  = l;
        right_sample = r;
        if (v) begin
            if (l == 0 && r == 0) begin
                if (run < RUN_LEN) run++;
            end else begin
                run = 0;
            end
        end
        exp_flag = (run >= RUN_LEN);
        exp_tag  = tag;
    endtask

    task automatic silent(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, '0, '0, tag);
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        check_now();
        rst_n = 1'b0;
        frame_valid = 1'b1;
        left_sample = '0;
        right_sample = '0;
        run = 0;
        exp_flag = 0;
        exp_tag = "R1 reset holds flag low";
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_now();
        end
        rst_n = 1'b1;
        frame_valid = 1'b0;
    endtask

    initial begin
        // R1: reset with silent strobes present, flag must stay low
        frame_valid = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check_now();
        end
        rst_n = 1'b1;
        frame_valid = 1'b0;

        // R2: threshold edge
        silent(RUN_LEN - 1, "R2 before threshold");
        step(1'b0, '0, '0, "R2 still low after RUN_LEN-1 frames");
        silent(1, "R2 rises at RUN_LEN frames");
        step(1'b0, '0, '0, "R2 high after threshold");

        // R5: long silence, no wrap
        silent(3000, "R5 saturated flag stays high");

        // R4: idle cycles carrying data are ignored while high
        for (int i = 0; i < 40; i++) step(1'b0, 24'h123456, 24'h800000, "R4 idle data ignored");

        // R3: left only nonzero
        step(1'b1, 24'h000010, '0, "R3 left nonzero clears");
        silent(RUN_LEN - 1, "R3 recount after left");
        silent(1, "R3 rises again after left");
        // R3: right only nonzero
        step(1'b1, '0, 24'hFFFFFF, "R3 right nonzero clears");
        silent(RUN_LEN, "R3 recount after right");

        // R7: MSB-only on right clears
        step(1'b1, '0, 24'h800000, "R7 most negative value is data");
        // R4: count by strobes only, idle cycles carry nonzero data
        for (int i = 0; i < RUN_LEN; i++) begin
            step(1'b1, '0, '0, "R4 strobed silent frame");
            step(1'b0, 24'h000001, 24'h000001, "R4 idle cycle no count");
            step(1'b0, 24'h7FFFFF, '0, "R4 idle cycle no count");
        end
        // R7: LSB-only on left clears
        step(1'b1, 24'h000001, '0, "R7 value one is data");
        silent(5, "R7 recount");

        // R6: one channel zero, other nonzero, never rises
        for (int i = 0; i < RUN_LEN + 200; i++)
            step(1'b1, '0, 24'h000002, "R6 one channel active");
        for (int i = 0; i < RUN_LEN + 200; i++)
            step(1'b1, 24'h400000, '0, "R6 other channel active");

        // R1: reset mid-run discards progress
        silent(600, "R1 pre-reset run");
        do_reset(3);
        silent(600, "R1 progress dropped by reset");
        silent(RUN_LEN - 600 - 1, "R1 one short after reset");
        silent(1, "R1 full run after reset");
        step(1'b0, '0, '0, "R1 high after full run");
        step(1'b0, '0, '0, "R1 final");

        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule